// File: doc/BRIEF.md
# Branch and Exception Redirect Controller

This block decides where instruction fetch goes next in a five-stage in-order pipeline and which pipeline registers are cleared on a redirect. It keeps the fetch program counter. By default fetch runs straight ahead, on the assumption that no branch is taken. A conditional branch is resolved in the decode stage. A dedicated adder there forms the target from the decode PC and the word offset, and an equality comparator tests the two register operands. A taken branch steers the PC to the target and clears the single wrong-path instruction in the fetch/decode register.

An arithmetic overflow reported by the execute stage makes the exception precise. The PC is loaded with a fixed handler address. The fetch/decode, decode/execute and execute/memory registers are cleared, so three bubbles enter the pipeline. Older instructions in memory and writeback finish normally. The PC carried in the decode/execute register is saved in an exception PC register, and a cause register records the exception kind. Overflow wins over a taken branch in the same cycle.

The flush and select outputs are combinational, so they act on the pipeline registers at the same clock edge that loads the new PC. The fetch PC, the exception PC and the cause are registers.

Top module: `redirect_ctrl`

## Requirements
- R1: While `rst` is high and after the first clock edge, `fetch_pc`, `epc` and `cause` are all zero.
- R2: When there is no overflow and no taken branch, `pc_sel` is 0 (sequential), `next_pc` equals `fetch_pc + 4`, and all three flush outputs are low.
- R3: A branch with `br_ne`=0 is taken when `rs_val == rt_val`. Then `pc_sel` is 1, `next_pc` equals `id_pc + 4 + (id_offset << 2)`, `flush_ifid` is high, and `flush_idex` and `flush_exmem` are low.
- R4: A branch with `br_ne`=0 and unequal operands is not taken and behaves exactly as R2.
- R5: A branch with `br_ne`=1 is taken when the operands differ, with the R3 outputs, and is not taken when they are equal.
- R6: A negative sign-extended offset gives a target below `id_pc + 4`, computed modulo 2^32.
- R7: When `ex_ovf` is high, `pc_sel` is 2, `next_pc` is the handler address 0x8000_0180, and all three flush outputs are high.
- R8: At the edge where `ex_ovf` is high, `epc` loads `ex_pc` and `cause` loads 12 (arithmetic overflow). Cause 0 means none. Code 10 (undefined instruction) is reserved.
- R9: When `ex_ovf` and a taken branch occur in the same cycle, the overflow outputs of R7 win.
- R10: Outside reset, `fetch_pc` takes the value `next_pc` had before each rising edge.
- R11: `epc` and `cause` keep their values in every cycle without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_pc | input | 32 | PC of the instruction in decode |
| id_offset | input | 32 | Sign-extended word offset of the decode branch |
| rs_val | input | 32 | First register operand in decode |
| rt_val | input | 32 | Second register operand in decode |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| br_ne | input | 1 | Branch polarity: 0 taken on equal, 1 taken on not equal |
| ex_ovf | input | 1 | Arithmetic overflow in execute |
| ex_pc | input | 32 | PC held in the decode/execute register (next instruction address) |
| fetch_pc | output | 32 | Registered fetch PC |
| next_pc | output | 32 | Value the PC takes at the next edge |
| pc_sel | output | 2 | PC mux select: 0 sequential, 1 branch, 2 exception |
| flush_ifid | output | 1 | Clear the fetch/decode register |
| flush_idex | output | 1 | Clear the decode/execute register |
| flush_exmem | output | 1 | Clear the execute/memory register |
| epc | output | 32 | Saved exception PC |
| cause | output | 5 | Exception cause code |

## Verification
The hardest case to reach from the ports is a cycle where an overflow in execute and a taken branch in decode arrive together, because a real pipeline seldom lines them up. The bench drives both conditions in one cycle. It checks that the handler address, the full three-stage flush and the saved PC win over the branch. It then confirms that the next fetch PC is the handler and not the branch target. A following idle cycle shows that the saved PC and the cause hold their values.

// File: rtl/redirect_pkg.sv
package redirect_pkg;
  localparam int XLEN    = 32;
  localparam int CAUSE_W = 5;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_EXC = 2'd2
  } pc_sel_e;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = 5'd10;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 5'd12;
endpackage

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int W = 32
) (
  input  logic [W-1:0] pc,
  input  logic [W-1:0] offset,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         is_branch,
  input  logic         invert,
  output logic [W-1:0] target,
  output logic         taken
);
  localparam int WORD_SHIFT = 2;
  localparam logic [W-1:0] INSN_BYTES = W'(4);

  logic same;

  always_comb begin
    target = pc + INSN_BYTES + (offset << WORD_SHIFT);
    same   = (op_a == op_b);
    taken  = is_branch && (same ^ invert);
  end
endmodule

// File: rtl/redirect_arb.sv
module redirect_arb
  import redirect_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] HANDLER = 32'h8000_0180
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] br_target,
  input  logic         br_taken,
  input  logic         ovf,
  output logic [1:0]   sel,
  output logic [W-1:0] nxt,
  output logic         fl_ifid,
  output logic         fl_idex,
  output logic         fl_exmem
);
  localparam logic [W-1:0] STEP = W'(4);

  pc_sel_e sel_e;

  always_comb begin
    if (ovf)           sel_e = SEL_EXC;
    else if (br_taken) sel_e = SEL_BR;
    else               sel_e = SEL_SEQ;

    unique case (sel_e)
      SEL_EXC: nxt = HANDLER;
      SEL_BR:  nxt = br_target;
      default: nxt = cur_pc + STEP;
    endcase

    fl_ifid  = (sel_e != SEL_SEQ);
    fl_idex  = (sel_e == SEL_EXC);
    fl_exmem = (sel_e == SEL_EXC);
    sel      = sel_e;
  end

  assert_ovf_flush_all_R7: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (fl_ifid && fl_idex && fl_exmem && nxt == HANDLER));
  assert_ovf_over_branch_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf && br_taken) |-> (sel == 2'd2));
  assert_branch_single_flush_R3: assert property (@(posedge clk) disable iff (rst)
    (br_taken && !ovf) |-> (fl_ifid && !fl_idex && !fl_exmem && nxt == br_target));
  assert_quiet_no_flush_R2: assert property (@(posedge clk) disable iff (rst)
    (!br_taken && !ovf) |-> (!fl_ifid && !fl_idex && !fl_exmem));
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import redirect_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ovf,
  input  logic [W-1:0]  saved_pc_in,
  output logic [W-1:0]  saved_pc,
  output logic [CW-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      saved_pc <= '0;
      code     <= CW'(CAUSE_NONE);
    end else if (ovf) begin
      saved_pc <= saved_pc_in;
      code     <= CW'(CAUSE_OVF);
    end
  end

  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf) && !$past(rst)) |-> (saved_pc == $past(saved_pc_in) && code == CW'(12)));
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(ovf) && !$past(rst)) |-> ($stable(saved_pc) && $stable(code)));
endmodule

// File: rtl/redirect_ctrl.sv
module redirect_ctrl
  import redirect_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int CW = CAUSE_W,
  parameter logic [W-1:0] HANDLER  = 32'h8000_0180,
  parameter logic [W-1:0] RESET_PC = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  id_pc,
  input  logic [W-1:0]  id_offset,
  input  logic [W-1:0]  rs_val,
  input  logic [W-1:0]  rt_val,
  input  logic          id_branch,
  input  logic          br_ne,
  input  logic          ex_ovf,
  input  logic [W-1:0]  ex_pc,
  output logic [W-1:0]  fetch_pc,
  output logic [W-1:0]  next_pc,
  output logic [1:0]    pc_sel,
  output logic          flush_ifid,
  output logic          flush_idex,
  output logic          flush_exmem,
  output logic [W-1:0]  epc,
  output logic [CW-1:0] cause
);
  logic [W-1:0] br_target;
  logic         br_taken;

  branch_resolve #(.W(W)) u_br (
    .pc(id_pc), .offset(id_offset), .op_a(rs_val), .op_b(rt_val),
    .is_branch(id_branch), .invert(br_ne),
    .target(br_target), .taken(br_taken)
  );

  redirect_arb #(.W(W), .HANDLER(HANDLER)) u_arb (
    .clk(clk), .rst(rst), .cur_pc(fetch_pc), .br_target(br_target),
    .br_taken(br_taken), .ovf(ex_ovf), .sel(pc_sel), .nxt(next_pc),
    .fl_ifid(flush_ifid), .fl_idex(flush_idex), .fl_exmem(flush_exmem)
  );

  exc_capture #(.W(W), .CW(CW)) u_exc (
    .clk(clk), .rst(rst), .ovf(ex_ovf), .saved_pc_in(ex_pc),
    .saved_pc(epc), .code(cause)
  );

  always_ff @(posedge clk) begin
    if (rst) fetch_pc <= RESET_PC;
    else     fetch_pc <= next_pc;
  end

  assert_pc_follows_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (fetch_pc == $past(next_pc)));
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (fetch_pc == RESET_PC && epc == '0 && cause == '0));
endmodule

// File: tb/tb_redirect_ctrl.sv
module tb_redirect_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] id_pc, id_offset, rs_val, rt_val, ex_pc;
  logic        id_branch, br_ne, ex_ovf;
  logic [31:0] fetch_pc, next_pc, epc;
  logic [1:0]  pc_sel;
  logic        flush_ifid, flush_idex, flush_exmem;
  logic [4:0]  cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] exp_pc;
  logic [31:0] exp_epc;
  logic [4:0]  exp_cause;

  localparam logic [31:0] HANDLER = 32'h8000_0180;

  always #2 clk = ~clk;

  redirect_ctrl dut (
    .clk(clk), .rst(rst), .id_pc(id_pc), .id_offset(id_offset),
    .rs_val(rs_val), .rt_val(rt_val), .id_branch(id_branch), .br_ne(br_ne),
    .ex_ovf(ex_ovf), .ex_pc(ex_pc), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pc_sel(pc_sel), .flush_ifid(flush_ifid), .flush_idex(flush_idex),
    .flush_exmem(flush_exmem), .epc(epc), .cause(cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    id_pc = 32'h0; id_offset = 32'h0; rs_val = 32'h0; rt_val = 32'h1;
    id_branch = 1'b0; br_ne = 1'b0; ex_ovf = 1'b0; ex_pc = 32'h0;
  endtask

  // drive at negedge, check comb outputs, then step one edge and check regs
  task automatic step_and_check_pc(input string req);
    @(posedge clk); #1;
    chk(req, fetch_pc, exp_pc);
    chk({req, "_epc"}, epc, exp_epc);
    chk({req, "_cause"}, {27'd0, cause}, {27'd0, exp_cause});
    @(negedge clk);
  endtask

  task automatic t_reset();
    idle_inputs(); rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R1_pc", fetch_pc, 32'h0);
    chk("R1_epc", epc, 32'h0);
    chk("R1_cause", {27'd0, cause}, 32'h0);
    @(negedge clk); rst = 1'b0;
    exp_pc = 32'h0; exp_epc = 32'h0; exp_cause = 5'd0;
  endtask

  task automatic t_sequential();
    for (int i = 0; i < 3; i++) begin
      idle_inputs(); #1;
      chk("R2_sel", {30'd0, pc_sel}, 32'd0);
      chk("R2_next", next_pc, exp_pc + 32'd4);
      chk("R2_flush", {29'd0, flush_ifid, flush_idex, flush_exmem}, 32'd0);
      exp_pc = exp_pc + 32'd4;
      step_and_check_pc("R10_seq");
    end
  endtask

  task automatic t_beq_taken();
    idle_inputs();
    id_pc = 32'h0000_0100; id_offset = 32'h0000_0010;
    rs_val = 32'hDEAD_BEEF; rt_val = 32'hDEAD_BEEF; id_branch = 1'b1; #1;
    chk("R3_sel", {30'd0, pc_sel}, 32'd1);
    chk("R3_next", next_pc, 32'h0000_0144);
    chk("R3_flush", {29'd0, flush_ifid, flush_idex, flush_exmem}, 32'b100);
    exp_pc = 32'h0000_0144;
    step_and_check_pc("R10_br");
  endtask

  task automatic t_beq_not_taken();
    idle_inputs();
    id_pc = 32'h0000_0200; id_offset = 32'h0000_0008;
    rs_val = 32'h5; rt_val = 32'h6; id_branch = 1'b1; #1;
    chk("R4_sel", {30'd0, pc_sel}, 32'd0);
    chk("R4_next", next_pc, exp_pc + 32'd4);
    chk("R4_flush", {29'd0, flush_ifid, flush_idex, flush_exmem}, 32'd0);
    exp_pc = exp_pc + 32'd4;
    step_and_check_pc("R4_pc");
    // branch flag low with equal operands is not a branch
    idle_inputs(); rs_val = 32'h7; rt_val = 32'h7; #1;
    chk("R2_nobr", {30'd0, pc_sel}, 32'd0);
    exp_pc = exp_pc + 32'd4;
    step_and_check_pc("R2_nobr_pc");
  endtask

  task automatic t_bne();
    idle_inputs();
    id_pc = 32'h0000_1000; id_offset = 32'h0000_0003;
    rs_val = 32'h1; rt_val = 32'h2; id_branch = 1'b1; br_ne = 1'b1; #1;
    chk("R5_taken_sel", {30'd0, pc_sel}, 32'd1);
    chk("R5_taken_next", next_pc, 32'h0000_1010);
    exp_pc = 32'h0000_1010;
    step_and_check_pc("R5_pc");
    rt_val = 32'h1; #1;
    chk("R5_eq_sel", {30'd0, pc_sel}, 32'd0);
    chk("R5_eq_flush", {31'd0, flush_ifid}, 32'd0);
    exp_pc = exp_pc + 32'd4;
    step_and_check_pc("R5_eq_pc");
  endtask

  task automatic t_negative_offset();
    idle_inputs();
    id_pc = 32'h0000_0040; id_offset = 32'hFFFF_FFF0;
    rs_val = 32'h9; rt_val = 32'h9; id_branch = 1'b1; #1;
    chk("R6_next", next_pc, 32'h0000_0004);
    exp_pc = 32'h0000_0004;
    step_and_check_pc("R6_pc");
    id_pc = 32'h0000_0000; id_offset = 32'hFFFF_FFFE; #1;
    chk("R6_wrap", next_pc, 32'hFFFF_FFFC);
    exp_pc = 32'hFFFF_FFFC;
    step_and_check_pc("R6_wrap_pc");
  endtask

  task automatic t_overflow();
    idle_inputs();
    ex_ovf = 1'b1; ex_pc = 32'h0000_2468; #1;
    chk("R7_sel", {30'd0, pc_sel}, 32'd2);
    chk("R7_next", next_pc, HANDLER);
    chk("R7_flush", {29'd0, flush_ifid, flush_idex, flush_exmem}, 32'b111);
    exp_pc = HANDLER; exp_epc = 32'h0000_2468; exp_cause = 5'd12;
    step_and_check_pc("R8_capture");
    idle_inputs(); ex_pc = 32'hAAAA_5554; #1;
    exp_pc = HANDLER + 32'd4;
    step_and_check_pc("R11_hold");
  endtask

  task automatic t_priority();
    idle_inputs();
    id_pc = 32'h0000_0300; id_offset = 32'h0000_0020;
    rs_val = 32'h3; rt_val = 32'h3; id_branch = 1'b1;
    ex_ovf = 1'b1; ex_pc = 32'h0000_0304; #1;
    chk("R9_sel", {30'd0, pc_sel}, 32'd2);
    chk("R9_next", next_pc, HANDLER);
    chk("R9_flush", {29'd0, flush_ifid, flush_idex, flush_exmem}, 32'b111);
    exp_pc = HANDLER; exp_epc = 32'h0000_0304; exp_cause = 5'd12;
    step_and_check_pc("R9_pc");
    idle_inputs(); ex_pc = 32'h1234_5678; #1;
    exp_pc = HANDLER + 32'd4;
    step_and_check_pc("R11_after");
  endtask

  task automatic t_reset_again();
    idle_inputs(); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1_epc_clear", epc, 32'h0);
    chk("R1_cause_clear", {27'd0, cause}, 32'h0);
    chk("R1_pc_clear", fetch_pc, 32'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs(); rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_sequential();
    t_beq_taken();
    t_beq_not_taken();
    t_bne();
    t_negative_offset();
    t_overflow();
    t_priority();
    t_reset_again();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule